// File: doc/BRIEF.md
# Interleaved Dual-Bank Byte Memory

This block is a byte-addressed RAM split into two equal banks. One bank holds the even addresses and the other holds the odd addresses. Both banks can act in the same clock cycle, and software still sees one flat memory eight bits wide. A single request port carries a valid strobe, an operation code, a byte address and sixteen bits of write data. Read results come back one clock later on a sixteen-bit return bus with a valid flag.

Two bytes that sit next to each other always live in different banks. A sixteen-bit access at any alignment therefore finishes in one cycle. A paired operation can read one byte and write its neighbour in the same cycle. When the access starts at an odd byte, the even bank serves the second byte from the next row up. The control logic adds one to that bank's row index and swaps the byte lanes. The address width is a parameter: the default of 12 bits gives a 4 KiB array, and 16 bits gives the full 64 KiB space.

Top module: `dual_bank_ram`

## Requirements
- R1: A byte write (op 1) stores wrData[7:0] at reqAddr. A byte read (op 0) returns the byte at reqAddr in rdData[7:0]. Both behave exactly as on a flat single-bank RAM.
- R2: A word write (op 3) at an even address A stores wrData[7:0] at A and wrData[15:8] at A+1. A word read (op 2) returns byte A in rdData[7:0] and byte A+1 in rdData[15:8].
- R3: Word reads and writes at an odd address A move bytes A and A+1 in one cycle, using the same little-endian lanes as R2. The even bank then uses row (A>>1)+1, while the odd bank uses row A>>1.
- R4: When A is the top address (all ones), the second byte of any two-byte operation is address 0.
- R5: The read-then-write op (op 4) returns byte A in rdData[7:0] and writes wrData[15:8] to A+1, both in the same cycle.
- R6: The write-then-read op (op 5) writes wrData[7:0] to A and returns byte A+1 in rdData[15:8], both in the same cycle.
- R7: rdValid is high in the cycle after an accepted op 0, 2, 4 or 5, and it is low in the cycle after any other request. rdData is valid while rdValid is high.
- R8: Any rdData lane that the operation did not read is zero: the upper lane after ops 0 and 4, and the lower lane after op 5.
- R9: A byte write raises the write enable of only the bank that holds the addressed byte.
- R10: A read issued in the cycle right after a write to the same byte returns the newly written value.
- R11: During and right after reset, rdValid is 0 and rdData is 0.
- R12: A request with reqValid low, or with the unused op codes 6 or 7, writes nothing and returns nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset of the response path |
| reqValid | input | 1 | Request strobe |
| reqOp | input | 3 | Operation code: 0 byte read, 1 byte write, 2 word read, 3 word write, 4 read A and write A+1, 5 write A and read A+1 |
| reqAddr | input | ADDR_W | Byte address A |
| wrData | input | 16 | Write data; the low lane belongs to A and the high lane to A+1 |
| rdValid | output | 1 | Read result valid, one clock after the request |
| rdData | output | 16 | Read result; the low lane is byte A and the high lane is byte A+1 |

## Verification
A wrong row increment or lane swap does not show up as a bad value when the write happens. It shows up only when a later read reaches one of the misplaced bytes, which can be many cycles later. To catch this, every byte the bench writes is compared against a flat reference array through reads at both alignments and at the wrap address. A response-path fault shows up right away. A wrong lane enable gives non-zero unread lanes or a misplaced rdValid in the very next cycle. A wrong bank write enable corrupts the neighbouring byte, and the next read that covers that byte exposes it.

// File: rtl/dbm_pkg.sv
package dbm_pkg;

  typedef enum logic [2:0] {
    OP_RD_BYTE = 3'd0,
    OP_WR_BYTE = 3'd1,
    OP_RD_WORD = 3'd2,
    OP_WR_WORD = 3'd3,
    OP_RD_WR   = 3'd4,
    OP_WR_RD   = 3'd5
  } memOp_e;

  // Per-request strobes from control to the datapath.
  typedef struct packed {
    logic evenWe;
    logic oddWe;
    logic evenRe;
    logic oddRe;
    logic oddFirst;   // A is odd: lanes swap between the banks
  } bankStrobes_t;

  // Registered response steering (one cycle after the request).
  typedef struct packed {
    logic loEn;
    logic hiEn;
    logic oddFirst;
  } rspSel_t;

endpackage

// File: rtl/dbm_bank.sv
module dbm_bank #(
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             we,
  input  logic             re,
  input  logic [ROW_W-1:0] row,
  input  logic [7:0]       wrByte,
  output logic [7:0]       rdByte
);
  localparam int DEPTH = 1 << ROW_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[row] <= wrByte;
    if (re) rdByte <= mem[row];
  end
endmodule

// File: rtl/dbm_ctrl.sv
module dbm_ctrl
  import dbm_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  output bankStrobes_t      strb,
  output logic [ADDR_W-2:0] evenRow,
  output logic [ADDR_W-2:0] oddRow,
  output rspSel_t           rspSel,
  output logic              rdValid
);
  localparam int ROW_W = ADDR_W - 1;

  logic loRe, hiRe, loWe, hiWe;
  logic oddFirst;
  logic [ROW_W-1:0] rowBase;

  // Lane-level decode: lo = byte A, hi = byte A+1.
  always_comb begin
    loRe = 1'b0;
    hiRe = 1'b0;
    loWe = 1'b0;
    hiWe = 1'b0;
    if (reqValid) begin
      case (reqOp)
        OP_RD_BYTE: loRe = 1'b1;
        OP_WR_BYTE: loWe = 1'b1;
        OP_RD_WORD: begin loRe = 1'b1; hiRe = 1'b1; end
        OP_WR_WORD: begin loWe = 1'b1; hiWe = 1'b1; end
        OP_RD_WR:   begin loRe = 1'b1; hiWe = 1'b1; end
        OP_WR_RD:   begin loWe = 1'b1; hiRe = 1'b1; end
        default:    ;
      endcase
    end
  end

  assign oddFirst = reqAddr[0];
  assign rowBase  = reqAddr[ADDR_W-1:1];

  // Bank steering: byte A goes to the bank picked by A[0].
  always_comb begin
    strb.oddFirst = oddFirst;
    strb.evenWe   = oddFirst ? hiWe : loWe;
    strb.oddWe    = oddFirst ? loWe : hiWe;
    strb.evenRe   = oddFirst ? hiRe : loRe;
    strb.oddRe    = oddFirst ? loRe : hiRe;
  end

  // For odd A the even bank holds A+1 in the next row; wraps at the top.
  assign evenRow = oddFirst ? rowBase + ROW_W'(1) : rowBase;
  assign oddRow  = rowBase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspSel <= '0;
    end else begin
      rspSel.loEn     <= loRe;
      rspSel.hiEn     <= hiRe;
      rspSel.oddFirst <= oddFirst;
    end
  end

  assign rdValid = rspSel.loEn | rspSel.hiEn;
endmodule

// File: rtl/dbm_datapath.sv
module dbm_datapath
  import dbm_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  bankStrobes_t      strb,
  input  logic [ADDR_W-2:0] evenRow,
  input  logic [ADDR_W-2:0] oddRow,
  input  logic [15:0]       wrData,
  input  rspSel_t           rspSel,
  output logic [15:0]       rdData
);
  localparam int ROW_W  = ADDR_W - 1;
  localparam int NBANKS = 2;

  logic             bankWe [NBANKS];
  logic             bankRe [NBANKS];
  logic [ROW_W-1:0] bankRow [NBANKS];
  logic [7:0]       bankWr [NBANKS];
  logic [7:0]       bankQ  [NBANKS];

  // Index 0 = even bank, index 1 = odd bank.
  always_comb begin
    bankWe[0]  = strb.evenWe;
    bankWe[1]  = strb.oddWe;
    bankRe[0]  = strb.evenRe;
    bankRe[1]  = strb.oddRe;
    bankRow[0] = evenRow;
    bankRow[1] = oddRow;
    bankWr[0]  = strb.oddFirst ? wrData[15:8] : wrData[7:0];
    bankWr[1]  = strb.oddFirst ? wrData[7:0]  : wrData[15:8];
  end

  for (genvar g = 0; g < NBANKS; g++) begin : g_bank
    dbm_bank #(.ROW_W(ROW_W)) u_bank (
      .clk    (clk),
      .we     (bankWe[g]),
      .re     (bankRe[g]),
      .row    (bankRow[g]),
      .wrByte (bankWr[g]),
      .rdByte (bankQ[g])
    );
  end

  logic [7:0] loByte, hiByte;
  assign loByte = rspSel.oddFirst ? bankQ[1] : bankQ[0];
  assign hiByte = rspSel.oddFirst ? bankQ[0] : bankQ[1];

  assign rdData = {rspSel.hiEn ? hiByte : 8'h00,
                   rspSel.loEn ? loByte : 8'h00};
endmodule

// File: rtl/dual_bank_ram.sv
module dual_bank_ram
  import dbm_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [15:0]       wrData,
  output logic              rdValid,
  output logic [15:0]       rdData
);
  bankStrobes_t      strb;
  rspSel_t           rspSel;
  logic [ADDR_W-2:0] evenRow;
  logic [ADDR_W-2:0] oddRow;

  dbm_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .reqAddr  (reqAddr),
    .strb     (strb),
    .evenRow  (evenRow),
    .oddRow   (oddRow),
    .rspSel   (rspSel),
    .rdValid  (rdValid)
  );

  dbm_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk     (clk),
    .strb    (strb),
    .evenRow (evenRow),
    .oddRow  (oddRow),
    .wrData  (wrData),
    .rspSel  (rspSel),
    .rdData  (rdData)
  );
endmodule

// File: rtl/dbm_checker.sv
module dbm_checker
  import dbm_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [2:0]        reqOp,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              rdValid,
  input logic [15:0]       rdData,
  input bankStrobes_t      strb,
  input logic [ADDR_W-2:0] evenRow,
  input logic [ADDR_W-2:0] oddRow
);
  logic isRead, isWrite, isByteWr, isLoOnlyRd, isHiOnlyRd;
  logic [ADDR_W-2:0] rowNext;

  always_comb begin
    isRead     = reqValid && (reqOp inside {3'd0, 3'd2, 3'd4, 3'd5});
    isWrite    = reqValid && (reqOp inside {3'd1, 3'd3, 3'd4, 3'd5});
    isByteWr   = reqValid && (reqOp == 3'd1);
    isLoOnlyRd = reqValid && (reqOp inside {3'd0, 3'd4});
    isHiOnlyRd = reqValid && (reqOp == 3'd5);
    rowNext    = oddRow + 1'b1;
  end

  p_rd_latency_r7: assert property (@(posedge clk) disable iff (!rstN)
    isRead |=> rdValid);

  p_no_spurious_rd_r7: assert property (@(posedge clk) disable iff (!rstN)
    !isRead |=> !rdValid);

  p_byte_we_one_bank_r9: assert property (@(posedge clk) disable iff (!rstN)
    isByteWr |-> ($countones({strb.evenWe, strb.oddWe}) == 1) && (strb.oddWe == reqAddr[0]));

  p_odd_row_skew_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAddr[0]) |-> (evenRow == rowNext) && (oddRow == reqAddr[ADDR_W-1:1]));

  p_idle_no_write_r12: assert property (@(posedge clk) disable iff (!rstN)
    !isWrite |-> !strb.evenWe && !strb.oddWe);

  p_hi_lane_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    isLoOnlyRd |=> rdData[15:8] == 8'h00);

  p_lo_lane_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    isHiOnlyRd |=> rdData[7:0] == 8'h00);
endmodule

bind dual_bank_ram dbm_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqOp    (reqOp),
  .reqAddr  (reqAddr),
  .rdValid  (rdValid),
  .rdData   (rdData),
  .strb     (strb),
  .evenRow  (evenRow),
  .oddRow   (oddRow)
);

// File: tb/dual_bank_ram_tb.sv
`timescale 1ns/1ps
module dual_bank_ram_tb;
  localparam int AW   = 12;
  localparam int SIZE = 1 << AW;
  localparam int MASK = SIZE - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [2:0]    reqOp = 3'd0;
  logic [AW-1:0] reqAddr = '0;
  logic [15:0]   wrData = '0;
  logic          rdValid;
  logic [15:0]   rdData;

  always #10 clk = ~clk;   // 50 MHz

  dual_bank_ram #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .wrData(wrData), .rdValid(rdValid), .rdData(rdData)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0]  refMem [SIZE];
  logic [15:0] expQ [$];
  string       tagQ [$];

  task automatic check(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: drives one request and pushes the expected result.
  task automatic issue(input logic [2:0] op, input int addr, input logic [15:0] d,
                       input string tag);
    int a = addr & MASK;
    int b = (addr + 1) & MASK;
    @(negedge clk);
    reqValid = 1'b1;
    reqOp    = op;
    reqAddr  = AW'(a);
    wrData   = d;
    case (op)
      3'd0: begin expQ.push_back({8'h00, refMem[a]}); tagQ.push_back(tag); end
      3'd1: refMem[a] = d[7:0];
      3'd2: begin expQ.push_back({refMem[b], refMem[a]}); tagQ.push_back(tag); end
      3'd3: begin refMem[a] = d[7:0]; refMem[b] = d[15:8]; end
      3'd4: begin expQ.push_back({8'h00, refMem[a]}); tagQ.push_back(tag);
                  refMem[b] = d[15:8]; end
      3'd5: begin expQ.push_back({refMem[b], 8'h00}); tagQ.push_back(tag);
                  refMem[a] = d[7:0]; end
      default: ;
    endcase
  endtask

  task automatic issueNoValid(input logic [2:0] op, input int addr, input logic [15:0] d);
    @(negedge clk);
    reqValid = 1'b0;
    reqOp    = op;
    reqAddr  = AW'(addr & MASK);
    wrData   = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reqValid = 1'b0;
    end
  endtask

  // Monitor: compares each result against the scoreboard head.
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R7 unexpected rdValid", rdData, 16'h0000);
      end else begin
        logic [15:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(rdData === e, t, rdData, e);
      end
    end
  end

  function automatic string randTag(input logic [2:0] op, input int a);
    if (a == MASK && op inside {3'd2, 3'd3, 3'd4, 3'd5}) return "R4";
    case (op)
      3'd0, 3'd1: return "R1";
      3'd2, 3'd3: return a[0] ? "R3" : "R2";
      3'd4:       return "R5";
      3'd5:       return "R6";
      default:    return "R12";
    endcase
  endfunction

  initial begin
    for (int i = 0; i < SIZE; i++) refMem[i] = 8'h00;
    // R11: reset state
    repeat (3) @(negedge clk);
    check(rdValid === 1'b0, "R11 rdValid in reset", {15'd0, rdValid}, 16'h0000);
    check(rdData === 16'h0000, "R11 rdData in reset", rdData, 16'h0000);
    rstN = 1'b1;
    @(negedge clk);
    check(rdValid === 1'b0, "R11 rdValid after reset", {15'd0, rdValid}, 16'h0000);
    check(rdData === 16'h0000, "R11 rdData after reset", rdData, 16'h0000);

    // Fill with aligned word writes (R2)
    for (int i = 0; i < SIZE / 2; i++)
      issue(3'd3, 2 * i, 16'(i * 16'h9E37 ^ 16'h5A5A), "R2");
    for (int i = 0; i < 16; i++) issue(3'd2, 2 * i, 16'h0, "R2 aligned word read");

    // R1 / R9 byte access next to untouched neighbours
    issue(3'd1, 101, 16'hAB3C, "R1");
    issue(3'd2, 100, 16'h0, "R9 neighbour of odd byte write");
    issue(3'd2, 101, 16'h0, "R9 neighbour above odd byte write");
    issue(3'd1, 200, 16'hCD7E, "R1");
    issue(3'd0, 200, 16'h0, "R1 byte read even");
    issue(3'd0, 201, 16'h0, "R9 odd neighbour unchanged");
    issue(3'd0, 199, 16'h0, "R9 lower neighbour unchanged");

    // R3 unaligned word
    issue(3'd3, 301, 16'h1234, "R3");
    issue(3'd2, 301, 16'h0, "R3 odd word read");
    issue(3'd2, 300, 16'h0, "R3 even view of odd write");
    issue(3'd2, 302, 16'h0, "R3 even view upper");

    // R4 wrap
    issue(3'd3, MASK, 16'hBEEF, "R4");
    issue(3'd0, MASK, 16'h0, "R4 top byte");
    issue(3'd0, 0, 16'h0, "R4 wrapped byte");
    issue(3'd2, MASK, 16'h0, "R4 wrap word read");
    issue(3'd4, MASK, 16'h7700, "R4 read-write wrap");
    issue(3'd0, 0, 16'h0, "R4 wrap after mixed op");

    // R5 / R6 mixed ops at both alignments
    issue(3'd4, 400, 16'h5500, "R5 even");
    issue(3'd0, 401, 16'h0, "R5 written neighbour");
    issue(3'd4, 411, 16'h6600, "R5 odd");
    issue(3'd2, 411, 16'h0, "R5 odd readback");
    issue(3'd5, 500, 16'h0044, "R6 even");
    issue(3'd0, 500, 16'h0, "R6 written byte");
    issue(3'd5, 511, 16'h0088, "R6 odd");
    issue(3'd2, 511, 16'h0, "R6 odd readback");

    // R10 read right after write
    issue(3'd1, 600, 16'h00A5, "R10");
    issue(3'd0, 600, 16'h0, "R10 byte");
    issue(3'd3, 603, 16'hC3D2, "R10");
    issue(3'd2, 603, 16'h0, "R10 odd word");

    // R12 ignored requests
    issueNoValid(3'd3, 700, 16'hFFFF);
    issue(3'd6, 701, 16'hEEEE, "R12");
    issue(3'd7, 702, 16'hDDDD, "R12");
    issue(3'd2, 700, 16'h0, "R12 no write by ignored request");
    issue(3'd2, 702, 16'h0, "R12 no write by reserved op");

    // Mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] op;
      int a;
      op = 3'($urandom_range(0, 7));
      a  = ($urandom_range(0, 15) == 0) ? MASK : int'($urandom_range(0, MASK));
      if ($urandom_range(0, 9) == 0) issueNoValid(op, a, 16'($urandom));
      else issue(op, a, 16'($urandom), randTag(op, a));
    end
    // Final sweep of the whole array
    for (int i = 0; i < SIZE / 2; i++) issue(3'd2, 2 * i, 16'h0, "R1 final sweep");

    idle(4);
    check(expQ.size() == 0, "R7 missing responses", 16'(expQ.size()), 16'h0000);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      check(1'b0, "watchdog expired", 16'h0, 16'h0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule